// File: doc/BRIEF.md
# Three-Level Surface Table Walker

This block resolves where the auxiliary data of a surface lives. Given a 48-bit main-surface address, it reads one 64-bit entry from each of three tables held in memory: a top table found at a programmed base, a middle table, and a leaf table. Each level takes its own slice of the address as an index, and each table pointer it finds has its own alignment. The leaf entry holds a 256-byte-aligned data pointer together with the surface attributes, and the block decodes them into separate result fields.

Requests arrive on a valid/ready handshake, and only one walk is in progress at a time. Reads leave through a plain request/response port that allows one outstanding read. A walk ends with a one-cycle result pulse. The pulse carries either a hit with the decoded fields, or a miss naming the level whose entry was not valid. After a miss the block issues no further reads for that walk.

Top module: `aux_surface_walker`

## Requirements
- R1: The first read of a walk goes to `tbl_base + 8*req_va[47:36]`. Address bits 15:0 have no effect on any read address or result field.
- R2: In a top entry, bit 0 is the valid flag. Bits 47:15, with 15 zero bits appended, form the middle-table pointer, which is sign-extended from bit 47 to 64 bits. All other bits of the top entry are ignored.
- R3: The second read goes to the middle-table pointer plus `8*req_va[35:24]`. In a middle entry, bit 0 is valid. Bits 47:13, with 13 zero bits appended and sign-extended from bit 47, form the leaf-table pointer.
- R4: The third read goes to the leaf-table pointer plus `8*req_va[23:16]`.
- R5: On a hit, the result fields are taken from the leaf entry as follows: `res_fmt` from bits 63:58, `res_ycr` from bit 57, `res_depth` from bits 56:54 and `res_tile` from bits 53:52. Bits 51:48 and 7:1 are ignored.
- R6: On a hit, `res_aux_addr` equals leaf bits 47:8 with eight zero bits appended, sign-extended from bit 47.
- R7: If the fetched entry has bit 0 clear, the walk ends after that read. The result reports `res_hit`=0 and `res_miss_lvl` = 1 (top), 2 (middle) or 3 (leaf). A hit reports `res_miss_lvl`=0 after exactly three reads.
- R8: `req_ready` falls in the cycle after a request is accepted and stays low through the single cycle in which `res_valid` is high. It is high again in the following cycle. No memory read is requested while `req_ready` is high.
- R9: `res_tile_err` is 1 only on a hit whose tile code is 2 or 3. On a miss, it and all attribute and address fields are zero.
- R10: `res_bpp` translates the depth code as 0→16, 1→10, 2→12, 4→8, 5→32, 6→64 and 7→128. Code 3 gives 0.
- R11: Once `mem_req_valid` is raised, it stays high with `mem_req_addr` unchanged until `mem_req_ready` is seen.
- R12: After reset, `req_ready`=1, `res_valid`=0 and `mem_req_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_va | input | 48 | Main-surface address to translate |
| tbl_base | input | 64 | Byte address of the top-level table |
| mem_req_valid | output | 1 | Read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the 64-bit entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry read from memory |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | All three levels were valid |
| res_miss_lvl | output | 2 | Level where the walk stopped (0 on hit) |
| res_aux_addr | output | 64 | Canonical aux data address |
| res_fmt | output | 6 | Format code |
| res_ycr | output | 1 | Y/Cr plane flag |
| res_depth | output | 3 | Depth code |
| res_tile | output | 2 | Tile mode (0 Ys, 1 Y) |
| res_bpp | output | 8 | Bits per pixel decoded from depth |
| res_tile_err | output | 1 | Reserved tile mode on a hit |

## Verification
The assertions rely on two properties of the memory side. First, it returns exactly one response for each accepted read. Second, it never raises `mem_rsp_valid` while no read is outstanding. The bench's memory model keeps to both by holding a single pending slot. It varies `mem_req_ready` and the response latency with a free-running cycle counter. Table contents are computed from the entry address by formula. The sweep covers top, middle and leaf indices at their extremes, places junk in ignored bits, and sets bit 47 in pointers to exercise sign extension.

// File: rtl/aux_walk_pkg.sv
package aux_walk_pkg;

  localparam int ENT_SH   = 3;
  localparam int FMT_LO   = 58;
  localparam int FMT_W    = 6;
  localparam int YCR_BIT  = 57;
  localparam int DEP_LO   = 54;
  localparam int DEP_W    = 3;
  localparam int TILE_LO  = 52;
  localparam int TILE_W   = 2;
  localparam int BPP_W    = 8;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_TOP  = 2'd1,
    LVL_MID  = 2'd2,
    LVL_LEAF = 2'd3
  } walk_lvl_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } walk_st_e;

  typedef struct packed {
    logic [FMT_W-1:0]  fmt;
    logic              ycr;
    logic [DEP_W-1:0]  depth;
    logic [TILE_W-1:0] tile;
    logic [BPP_W-1:0]  bpp;
    logic              tile_err;
  } leaf_attr_t;

endpackage

// File: rtl/aux_walk_addr.sv
module aux_walk_addr
  import aux_walk_pkg::*;
#(
  parameter int VA_W       = 48,
  parameter int PA_W       = 64,
  parameter int ENT_W      = 64,
  parameter int TOP_LO     = 36,
  parameter int TOP_IDX_W  = 12,
  parameter int MID_LO     = 24,
  parameter int MID_IDX_W  = 12,
  parameter int LEAF_LO    = 16,
  parameter int LEAF_IDX_W = 8,
  parameter int MID_ALIGN  = 15,
  parameter int LEAF_ALIGN = 13
) (
  input  walk_lvl_e        lvl,
  input  logic [VA_W-1:0]  va,
  input  logic [PA_W-1:0]  base,
  input  logic [ENT_W-1:0] entry,
  output logic [PA_W-1:0]  rd_addr
);

  localparam int NPTR = 2;
  localparam int PTR_ALIGN [NPTR] = '{MID_ALIGN, LEAF_ALIGN};
  localparam int EXT_W = PA_W - VA_W;

  logic [PA_W-1:0] tbl_ptr [NPTR];
  logic [PA_W-1:0] top_off, mid_off, leaf_off;

  // The middle and leaf pointers differ only in alignment
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic [VA_W-1:0] raw;
    assign raw        = {entry[VA_W-1:PTR_ALIGN[g]], {PTR_ALIGN[g]{1'b0}}};
    assign tbl_ptr[g] = {{EXT_W{raw[VA_W-1]}}, raw};
  end

  assign top_off  = PA_W'(va[TOP_LO  +: TOP_IDX_W])  << ENT_SH;
  assign mid_off  = PA_W'(va[MID_LO  +: MID_IDX_W])  << ENT_SH;
  assign leaf_off = PA_W'(va[LEAF_LO +: LEAF_IDX_W]) << ENT_SH;

  always_comb begin
    unique case (lvl)
      LVL_MID:  rd_addr = tbl_ptr[0] + mid_off;
      LVL_LEAF: rd_addr = tbl_ptr[1] + leaf_off;
      default:  rd_addr = base + top_off;
    endcase
  end

endmodule

// File: rtl/aux_walk_leaf_dec.sv
module aux_walk_leaf_dec
  import aux_walk_pkg::*;
#(
  parameter int VA_W      = 48,
  parameter int PA_W      = 64,
  parameter int ENT_W     = 64,
  parameter int AUX_ALIGN = 8
) (
  input  logic [ENT_W-1:0] entry,
  input  logic             hit,
  output leaf_attr_t       attr,
  output logic [PA_W-1:0]  aux_addr
);

  localparam int EXT_W = PA_W - VA_W;

  logic [VA_W-1:0]   aux_raw;
  logic [DEP_W-1:0]  dep;
  logic [TILE_W-1:0] tile;
  logic [BPP_W-1:0]  bpp;

  assign aux_raw = {entry[VA_W-1:AUX_ALIGN], {AUX_ALIGN{1'b0}}};
  assign dep     = entry[DEP_LO +: DEP_W];
  assign tile    = entry[TILE_LO +: TILE_W];

  always_comb begin
    unique case (dep)
      3'd0:    bpp = 8'd16;
      3'd1:    bpp = 8'd10;
      3'd2:    bpp = 8'd12;
      3'd4:    bpp = 8'd8;
      3'd5:    bpp = 8'd32;
      3'd6:    bpp = 8'd64;
      3'd7:    bpp = 8'd128;
      default: bpp = 8'd0;
    endcase
  end

  always_comb begin
    attr     = '0;
    aux_addr = '0;
    if (hit) begin
      attr.fmt      = entry[FMT_LO +: FMT_W];
      attr.ycr      = entry[YCR_BIT];
      attr.depth    = dep;
      attr.tile     = tile;
      attr.bpp      = bpp;
      attr.tile_err = tile[TILE_W-1];
      aux_addr      = {{EXT_W{aux_raw[VA_W-1]}}, aux_raw};
    end
  end

endmodule

// File: rtl/aux_walk_ctrl.sv
module aux_walk_ctrl
  import aux_walk_pkg::*;
#(
  parameter int VA_W  = 48,
  parameter int PA_W  = 64,
  parameter int ENT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic [PA_W-1:0]  req_base,
  output logic [VA_W-1:0]  va_q,
  output logic [PA_W-1:0]  base_q,
  output walk_lvl_e        lvl_q,
  output logic [ENT_W-1:0] entry_q,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  input  logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             res_valid,
  output logic             hit_q,
  output walk_lvl_e        miss_q
);

  walk_st_e  state_q, state_d;
  walk_lvl_e lvl_d, miss_d;
  logic      hit_d;
  logic      ld_req, ld_ent;

  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    hit_d   = hit_q;
    miss_d  = miss_q;
    ld_req  = 1'b0;
    ld_ent  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_req  = 1'b1;
          lvl_d   = LVL_TOP;
          hit_d   = 1'b0;
          miss_d  = LVL_NONE;
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (mem_req_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          ld_ent = 1'b1;
          if (!mem_rsp_data[0]) begin
            miss_d  = lvl_q;
            state_d = ST_DONE;
          end else if (lvl_q == LVL_LEAF) begin
            hit_d   = 1'b1;
            state_d = ST_DONE;
          end else begin
            lvl_d   = walk_lvl_e'(lvl_q + 2'd1);
            state_d = ST_ISSUE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= LVL_NONE;
      hit_q   <= 1'b0;
      miss_q  <= LVL_NONE;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      hit_q   <= hit_d;
      miss_q  <= miss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      base_q <= '0;
    end else if (ld_req) begin
      va_q   <= req_va;
      base_q <= req_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      entry_q <= '0;
    else if (ld_ent) entry_q <= mem_rsp_data;
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign res_valid     = (state_q == ST_DONE);

  assert_hold_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  assert_result_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid && req_ready);

  assert_no_read_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);

  assert_outcome_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (hit_q != (miss_q != LVL_NONE)));

endmodule

// File: rtl/aux_surface_walker.sv
module aux_surface_walker
  import aux_walk_pkg::*;
#(
  parameter int VA_W       = 48,
  parameter int PA_W       = 64,
  parameter int ENT_W      = 64,
  parameter int TOP_LO     = 36,
  parameter int TOP_IDX_W  = 12,
  parameter int MID_LO     = 24,
  parameter int MID_IDX_W  = 12,
  parameter int LEAF_LO    = 16,
  parameter int LEAF_IDX_W = 8,
  parameter int MID_ALIGN  = 15,
  parameter int LEAF_ALIGN = 13,
  parameter int AUX_ALIGN  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [PA_W-1:0]   tbl_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data,
  output logic              res_valid,
  output logic              res_hit,
  output logic [1:0]        res_miss_lvl,
  output logic [PA_W-1:0]   res_aux_addr,
  output logic [FMT_W-1:0]  res_fmt,
  output logic              res_ycr,
  output logic [DEP_W-1:0]  res_depth,
  output logic [TILE_W-1:0] res_tile,
  output logic [BPP_W-1:0]  res_bpp,
  output logic              res_tile_err
);

  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  base_q;
  logic [ENT_W-1:0] entry_q;
  walk_lvl_e        lvl_q, miss_q;
  logic             hit_q;
  leaf_attr_t       attr;

  aux_walk_ctrl #(
    .VA_W(VA_W), .PA_W(PA_W), .ENT_W(ENT_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_va        (req_va),
    .req_base      (tbl_base),
    .va_q          (va_q),
    .base_q        (base_q),
    .lvl_q         (lvl_q),
    .entry_q       (entry_q),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .res_valid     (res_valid),
    .hit_q         (hit_q),
    .miss_q        (miss_q)
  );

  aux_walk_addr #(
    .VA_W(VA_W), .PA_W(PA_W), .ENT_W(ENT_W),
    .TOP_LO(TOP_LO), .TOP_IDX_W(TOP_IDX_W),
    .MID_LO(MID_LO), .MID_IDX_W(MID_IDX_W),
    .LEAF_LO(LEAF_LO), .LEAF_IDX_W(LEAF_IDX_W),
    .MID_ALIGN(MID_ALIGN), .LEAF_ALIGN(LEAF_ALIGN)
  ) u_addr (
    .lvl     (lvl_q),
    .va      (va_q),
    .base    (base_q),
    .entry   (entry_q),
    .rd_addr (mem_req_addr)
  );

  aux_walk_leaf_dec #(
    .VA_W(VA_W), .PA_W(PA_W), .ENT_W(ENT_W), .AUX_ALIGN(AUX_ALIGN)
  ) u_leaf (
    .entry    (entry_q),
    .hit      (hit_q),
    .attr     (attr),
    .aux_addr (res_aux_addr)
  );

  assign res_hit      = hit_q;
  assign res_miss_lvl = miss_q;
  assign res_fmt      = attr.fmt;
  assign res_ycr      = attr.ycr;
  assign res_depth    = attr.depth;
  assign res_tile     = attr.tile;
  assign res_bpp      = attr.bpp;
  assign res_tile_err = attr.tile_err;

  assert_miss_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> !res_tile_err && res_aux_addr == '0 && res_fmt == '0);

  assert_tile_err_hit_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_tile_err |-> res_hit && res_tile[1]);

  assert_hit_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_hit |-> res_miss_lvl == 2'd0);

endmodule

// File: tb/aux_surface_walker_tb.sv
module aux_surface_walker_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] TOPB  = 64'h0000_0000_1000_0000;
  localparam logic [63:0] MIDB  = 64'hFFFF_8000_0000_0000;
  localparam logic [63:0] LEAFB = 64'h0000_4000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [47:0] req_va;
  logic [63:0] tbl_base;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        res_valid, res_hit, res_ycr, res_tile_err;
  logic [1:0]  res_miss_lvl, res_tile;
  logic [63:0] res_aux_addr;
  logic [5:0]  res_fmt;
  logic [2:0]  res_depth;
  logic [7:0]  res_bpp;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_surface_walker u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .tbl_base(tbl_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss_lvl(res_miss_lvl),
    .res_aux_addr(res_aux_addr), .res_fmt(res_fmt), .res_ycr(res_ycr),
    .res_depth(res_depth), .res_tile(res_tile), .res_bpp(res_bpp),
    .res_tile_err(res_tile_err)
  );

  // Table contents as a pure function of the entry address
  function automatic logic [63:0] mem_fn(input logic [63:0] a);
    logic [63:0] off, t, j, k, key, aux, e;
    logic v;
    e = '0;
    if (a >= TOPB && a < TOPB + 64'h8000) begin
      off = a - TOPB; t = off >> 3; v = (t % 4) != 3;
      e = 64'hA5A5_0000_0000_0000 | (64'h8000_0000_0000 + (t << 15))
          | ((t << 1) & 64'h7ffe) | 64'(v);
    end else if (a >= MIDB) begin
      off = a - MIDB; t = off >> 15; j = (off >> 3) & 64'hfff;
      v = ((t + j) % 4) != 3;
      e = 64'h5A5A_0000_0000_0000 | (LEAFB + (((t << 12) | j) << 13))
          | ((j << 1) & 64'h1ffe) | 64'(v);
    end else if (a >= LEAFB) begin
      off = a - LEAFB; key = off >> 13; k = (off >> 3) & 64'hff;
      v = (k % 5) != 4;
      aux = ((key << 8) | k) << 8;
      if (key[0]) aux = aux | 64'h8000_0000_0000;
      e = (((k * 7 + key) % 64) << 58) | ((k & 1) << 57) | ((k % 8) << 54)
          | (((k >> 1) % 4) << 52) | ((k & 15) << 48) | aux
          | ((k << 1) & 64'hfe) | 64'(v);
    end
    return e;
  endfunction

  function automatic logic [7:0] bpp_of(input logic [2:0] d);
    case (d)
      3'd0: return 8'd16;  3'd1: return 8'd10;  3'd2: return 8'd12;
      3'd4: return 8'd8;   3'd5: return 8'd32;  3'd6: return 8'd64;
      3'd7: return 8'd128; default: return 8'd0;
    endcase
  endfunction

  // Memory model: one pending read, varying ready and latency
  int          cyc = 0;
  int          rd_n = 0;
  logic [63:0] rd_log [4];
  logic        pend = 1'b0;
  logic [63:0] pend_addr;
  int          lat;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 1;
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      if (lat == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem_fn(pend_addr);
        pend          <= 1'b0;
      end else begin
        lat <= lat - 1;
      end
    end else if (mem_req_valid && mem_req_ready) begin
      pend         <= 1'b1;
      pend_addr    <= mem_req_addr;
      lat          <= cyc % 3;
      rd_log[rd_n % 4] <= mem_req_addr;
      rd_n         <= rd_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic walk(input logic [11:0] t, input logic [11:0] j, input logic [7:0] k,
                      input logic [15:0] lo);
    logic [63:0] e_rd [3];
    logic [63:0] leaf, aux;
    int exp_n, start, n;
    bit busy_bad;
    logic [1:0] exp_lvl;
    logic hit;
    e_rd[0] = TOPB + 64'(t) * 8;
    e_rd[1] = MIDB + 64'(t) * 64'h8000 + 64'(j) * 8;
    e_rd[2] = LEAFB + ((64'(t) << 12 | 64'(j)) << 13) + 64'(k) * 8;
    if ((t % 4) == 3)              begin exp_lvl = 2'd1; exp_n = 1; end
    else if (((t + j) % 4) == 3)   begin exp_lvl = 2'd2; exp_n = 2; end
    else if ((k % 5) == 4)         begin exp_lvl = 2'd3; exp_n = 3; end
    else                           begin exp_lvl = 2'd0; exp_n = 3; end
    hit = (exp_lvl == 2'd0);

    while (!req_ready) @(negedge clk);
    start = rd_n;
    req_valid = 1'b1;
    req_va = {t, j, k, lo};
    @(negedge clk);
    req_valid = 1'b0;
    req_va = '0;
    busy_bad = 1'b0;
    n = 0;
    while (!res_valid && n < 200) begin
      if (req_ready) busy_bad = 1'b1;
      @(negedge clk);
      n++;
    end
    chk(!busy_bad && !req_ready && res_valid, "R8 busy until result", 64'(req_ready), 0);
    chk(res_miss_lvl == exp_lvl && res_hit == hit, "R7 outcome level",
        64'(res_miss_lvl), 64'(exp_lvl));
    chk((rd_n - start) == exp_n, "R7 read count", 64'(rd_n - start), 64'(exp_n));
    for (int i = 0; i < exp_n && i < 3; i++) begin
      case (i)
        0: chk(rd_log[(start + i) % 4] == e_rd[i], "R1 top read addr", rd_log[(start + i) % 4], e_rd[i]);
        1: chk(rd_log[(start + i) % 4] == e_rd[i], "R2 R3 middle read addr", rd_log[(start + i) % 4], e_rd[i]);
        default: chk(rd_log[(start + i) % 4] == e_rd[i], "R4 leaf read addr", rd_log[(start + i) % 4], e_rd[i]);
      endcase
    end
    if (hit) begin
      leaf = mem_fn(e_rd[2]);
      aux  = {{16{leaf[47]}}, leaf[47:8], 8'h00};
      chk(res_aux_addr == aux, "R6 aux addr", res_aux_addr, aux);
      chk({res_fmt, res_ycr, res_depth, res_tile} == leaf[63:52], "R5 leaf fields",
          64'({res_fmt, res_ycr, res_depth, res_tile}), 64'(leaf[63:52]));
      chk(res_bpp == bpp_of(leaf[56:54]), "R10 bpp", 64'(res_bpp), 64'(bpp_of(leaf[56:54])));
      chk(res_tile_err == leaf[53], "R9 tile error on hit", 64'(res_tile_err), 64'(leaf[53]));
    end else begin
      chk(res_aux_addr == 0 && res_fmt == 0 && !res_tile_err && res_bpp == 0,
          "R9 miss fields zero", res_aux_addr, 0);
    end
    @(negedge clk);
    chk(!res_valid && req_ready, "R8 pulse and ready again", 64'({res_valid, req_ready}), 64'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    automatic int ts[6] = '{0, 1, 2, 3, 6, 4095};
    automatic int js[5] = '{0, 1, 3, 4094, 4095};
    automatic int ks[7] = '{0, 1, 2, 4, 5, 9, 255};
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_va = '0;
    tbl_base = TOPB;
    repeat (3) @(negedge clk);
    chk(req_ready && !res_valid && !mem_req_valid, "R12 reset state",
        64'({req_ready, res_valid, mem_req_valid}), 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 5; b++)
        for (int c = 0; c < 7; c++)
          walk(12'(ts[a]), 12'(js[b]), 8'(ks[c]), 16'((a * 977 + b * 131 + c * 4663) & 16'hffff));
    // R1: low address bits change nothing
    walk(12'd1, 12'd3, 8'd9, 16'h0000);
    walk(12'd1, 12'd3, 8'd9, 16'hFFFF);
    for (int c = 0; c < 256; c += 17) walk(12'd2, 12'd4094, 8'(c), 16'h1234);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule